// File: doc/BRIEF.md
# ADC Result Window Watcher

This block sits beside an analog-to-digital converter and inspects every conversion result as it is produced. A result arrives as a one-cycle valid strobe carrying a channel number and an unsigned 10-bit value. Each of up to six independent watch slots is programmed with a channel, a low limit, a high limit and a mode. A slot whose channel matches raises its alarm when the result lies above the high limit, below the low limit, or outside the window the two limits define, depending on the mode.

Alarms are held in sticky per-slot flags until software clears them by writing ones to a clear word. A single interrupt line is raised while any flag whose slot has its interrupt enable set is active. Configuration uses a plain write-only port. Each write to an address is a single-cycle strobe with an address and a data word.

Top module: `adc_window_watch`

## Requirements
- R1: While rst_n is low at a rising clock edge, all flags and the interrupt go to 0, every slot is set to mode 00, channel 0, low limit 0, high limit all ones and interrupt enable 0.
- R2: A slot evaluates a result only on a cycle with res_valid high and res_ch equal to its programmed channel; mode 00 never alarms.
- R3: Mode 01 alarms when the result is greater than the slot's high limit.
- R4: Mode 10 alarms when the result is less than the slot's low limit.
- R5: Mode 11 alarms when the result is less than the low limit or greater than the high limit.
- R6: Comparisons are unsigned and strict; a result equal to a limit never alarms.
- R7: A breaking result sets the slot's flag at the clock edge that samples the strobe, and the flag stays set through any number of later cycles until it is cleared.
- R8: A write to address 0x1C clears flag i for each data bit i that is 1 and leaves flags whose bit is 0 untouched; when a breaking result and a clear of the same slot fall in one cycle, the flag ends set.
- R9: alarm_irq is high exactly when some slot has both its flag and its interrupt enable set, in the same cycle as the flags.
- R10: Write address bits [4:2] select the slot and bits [1:0] the field: field 0 takes the channel from data[5:0], the mode from data[9:8] and the interrupt enable from data[12]; field 1 takes the low limit from data[9:0]; field 2 takes the high limit from data[9:0]. A result in the same cycle as a write is judged with the configuration before the write.
- R11: Slots act independently: one result can set several flags, and writes to slot numbers at or above the slot count change no flag and no slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Write address: slot in [4:2], field in [1:0]; 0x1C is the flag clear word |
| wr_data | input | 16 | Write data |
| res_valid | input | 1 | Conversion result valid, one cycle per result |
| res_ch | input | 6 | Channel number of the result |
| res_val | input | 10 | Unsigned result value |
| alarm_flags | output | 6 | Sticky alarm flag per slot |
| alarm_irq | output | 1 | OR of flags gated by their slot's interrupt enable |

## Verification
A result strobe sampled at one rising edge shows in alarm_flags, and in alarm_irq with no further delay, right after that edge; a configuration write is visible to the results of the following cycle, and a clear acts at the edge that samples it. The bench holds its inputs from a falling edge, advances a behavioural model at the rising edge with the same inputs, and compares the flags and interrupt at the next falling edge, so every result is checked in the very cycle it is due. Directed sections cover limit equality, same-cycle set and clear, same-cycle write and result and gated interrupts, then a long mixed random run compares every cycle.

// File: rtl/adc_watch_pkg.sv
// Shared encodings of the ADC result window watcher.
// Assumes: control word layout is fixed by the register map in the brief.
package adc_watch_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_ABOVE   = 2'b01,
        MODE_BELOW   = 2'b10,
        MODE_OUTSIDE = 2'b11
    } watch_mode_e;

    localparam logic [1:0] FIELD_CTRL = 2'd0;
    localparam logic [1:0] FIELD_LOW  = 2'd1;
    localparam logic [1:0] FIELD_HIGH = 2'd2;

    localparam int CTRL_MODE_LSB = 8;
    localparam int CTRL_IEN_BIT  = 12;

endpackage

// File: rtl/adc_watch_wdec.sv
// Write decoder: splits the configuration write port into per-slot field
// strobes and the flag clear strobe.
// Assumes: NUM_SLOTS is below 2**(ADDR_W-2); the all-ones slot number with
// field 0 is the clear word.
module adc_watch_wdec
    import adc_watch_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int ADDR_W    = 5
) (
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    output logic [NUM_SLOTS-1:0] ctrl_we,
    output logic [NUM_SLOTS-1:0] low_we,
    output logic [NUM_SLOTS-1:0] high_we,
    output logic                 clr_we
);
    localparam int SLOT_IDX_W = ADDR_W - 2;
    localparam logic [SLOT_IDX_W-1:0] CLR_SLOT = '1;

    logic [SLOT_IDX_W-1:0] slot_sel;
    logic [1:0]            field_sel;

    assign slot_sel  = wr_addr[ADDR_W-1:2];
    assign field_sel = wr_addr[1:0];

    // Clear word strobe.
    assign clr_we = wr_en && (slot_sel == CLR_SLOT) && (field_sel == FIELD_CTRL);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
        // Field strobes for slot i.
        assign ctrl_we[i] = wr_en && (slot_sel == SLOT_IDX_W'(i)) && (field_sel == FIELD_CTRL);
        assign low_we[i]  = wr_en && (slot_sel == SLOT_IDX_W'(i)) && (field_sel == FIELD_LOW);
        assign high_we[i] = wr_en && (slot_sel == SLOT_IDX_W'(i)) && (field_sel == FIELD_HIGH);
    end

endmodule

// File: rtl/adc_watch_cmp.sv
// Window comparator: decides whether a value breaks the condition selected
// by the mode. Purely combinational, unsigned, strict.
module adc_watch_cmp
    import adc_watch_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] value,
    input  logic [RES_W-1:0] low_lim,
    input  logic [RES_W-1:0] high_lim,
    input  watch_mode_e      mode,
    output logic             breach
);
    logic is_above;
    logic is_below;

    assign is_above = value > high_lim;
    assign is_below = value < low_lim;

    // Mode selection of the breaking condition.
    always_comb begin
        unique case (mode)
            MODE_ABOVE:   breach = is_above;
            MODE_BELOW:   breach = is_below;
            MODE_OUTSIDE: breach = is_above || is_below;
            default:      breach = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_watch_slot.sv
// One watch slot: holds its configuration, judges matching results and keeps
// the sticky alarm flag.
// Assumes: DATA_W is wide enough for the control word and for RES_W and CH_W.
module adc_watch_slot
    import adc_watch_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CH_W   = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              low_we,
    input  logic              high_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_req,
    input  logic              res_valid,
    input  logic [CH_W-1:0]   res_ch,
    input  logic [RES_W-1:0]  res_val,
    output logic              flag,
    output logic              irq_en,
    output logic              hit
);
    logic [CH_W-1:0]  ch_q;
    watch_mode_e      mode_q;
    logic [RES_W-1:0] low_q;
    logic [RES_W-1:0] high_q;
    logic             ien_q;
    logic             breach;
    logic             unused_bits;

    assign unused_bits = ^wr_data;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            mode_q <= MODE_OFF;
            low_q  <= '0;
            high_q <= '1;
            ien_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ch_q   <= wr_data[CH_W-1:0];
                mode_q <= watch_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
                ien_q  <= wr_data[CTRL_IEN_BIT];
            end
            if (low_we)  low_q  <= wr_data[RES_W-1:0];
            if (high_we) high_q <= wr_data[RES_W-1:0];
        end
    end

    adc_watch_cmp #(.RES_W(RES_W)) u_cmp (
        .value    (res_val),
        .low_lim  (low_q),
        .high_lim (high_q),
        .mode     (mode_q),
        .breach   (breach)
    );

    assign hit    = res_valid && (res_ch == ch_q) && breach;
    assign irq_en = ien_q;

    // Sticky flag: a new alarm takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (hit)     flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

endmodule

// File: rtl/adc_window_watch.sv
// ADC result window watcher top: decodes writes, instantiates the watch
// slots and combines their flags into one interrupt.
// Assumes: NUM_SLOTS <= DATA_W and NUM_SLOTS < 2**(ADDR_W-2).
module adc_window_watch #(
    parameter int NUM_SLOTS = 6,
    parameter int RES_W     = 10,
    parameter int CH_W      = 6,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 res_valid,
    input  logic [CH_W-1:0]      res_ch,
    input  logic [RES_W-1:0]     res_val,
    output logic [NUM_SLOTS-1:0] alarm_flags,
    output logic                 alarm_irq
);
    logic [NUM_SLOTS-1:0] ctrl_we;
    logic [NUM_SLOTS-1:0] low_we;
    logic [NUM_SLOTS-1:0] high_we;
    logic                 clr_we;
    logic [NUM_SLOTS-1:0] slot_ien;
    logic [NUM_SLOTS-1:0] slot_hit;

    adc_watch_wdec #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_wdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .ctrl_we (ctrl_we),
        .low_we  (low_we),
        .high_we (high_we),
        .clr_we  (clr_we)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        adc_watch_slot #(.RES_W(RES_W), .CH_W(CH_W), .DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_we   (ctrl_we[i]),
            .low_we    (low_we[i]),
            .high_we   (high_we[i]),
            .wr_data   (wr_data),
            .clr_req   (clr_we && wr_data[i]),
            .res_valid (res_valid),
            .res_ch    (res_ch),
            .res_val   (res_val),
            .flag      (alarm_flags[i]),
            .irq_en    (slot_ien[i]),
            .hit       (slot_hit[i])
        );
    end

    // Interrupt combine: any enabled flag.
    assign alarm_irq = |(alarm_flags & slot_ien);

endmodule

// File: rtl/adc_window_watch_chk.sv
// Property checker for the ADC result window watcher, bound to the top.
module adc_window_watch_chk #(
    parameter int NUM_SLOTS = 6,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [DATA_W-1:0]    wr_data,
    input logic                 res_valid,
    input logic [NUM_SLOTS-1:0] alarm_flags,
    input logic                 alarm_irq,
    input logic [NUM_SLOTS-1:0] slot_hit
);
    localparam logic [ADDR_W-1:0] CLR_ADDR = {{(ADDR_W-2){1'b1}}, 2'b00};

    logic [NUM_SLOTS-1:0] clr_vec;
    assign clr_vec = (wr_en && (wr_addr == CLR_ADDR)) ? wr_data[NUM_SLOTS-1:0] : '0;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (alarm_flags == '0) && !alarm_irq);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flags != '0));

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            alarm_flags[i] && !clr_vec[i] |=> alarm_flags[i]);

        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            slot_hit[i] |=> alarm_flags[i]);

        a_r8_clear_acts: assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] && !slot_hit[i] |=> !alarm_flags[i]);

        a_r2_rise_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alarm_flags[i]) |-> $past(res_valid));
    end

endmodule

bind adc_window_watch adc_window_watch_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .res_valid   (res_valid),
    .alarm_flags (alarm_flags),
    .alarm_irq   (alarm_irq),
    .slot_hit    (slot_hit)
);

// File: tb/adc_window_watch_tb.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model compared with the design every cycle.
module adc_window_watch_tb;
    localparam int NS = 6;
    localparam int RW = 10;
    localparam int CW = 6;
    localparam int DW = 16;
    localparam int AW = 5;
    localparam int CLR = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          res_valid = 1'b0;
    logic [CW-1:0] res_ch = '0;
    logic [RW-1:0] res_val = '0;
    logic [NS-1:0] flags;
    logic          irq;

    always #10 clk = ~clk;

    adc_window_watch u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .res_valid (res_valid), .res_ch (res_ch),
        .res_val (res_val), .alarm_flags (flags), .alarm_irq (irq)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    int    m_ch[NS], m_mode[NS], m_lo[NS], m_hi[NS];
    bit    m_en[NS], m_flag[NS];

    function automatic void model_step();
        bit hit[NS];
        bit b;
        int v, slot, fld;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_ch[i] = 0; m_mode[i] = 0; m_lo[i] = 0; m_hi[i] = (1 << RW) - 1;
                m_en[i] = 0; m_flag[i] = 0;
            end
            return;
        end
        v = int'(res_val);
        for (int i = 0; i < NS; i++) begin
            case (m_mode[i])
                1: b = v > m_hi[i];
                2: b = v < m_lo[i];
                3: b = (v < m_lo[i]) || (v > m_hi[i]);
                default: b = 0;
            endcase
            hit[i] = res_valid && (int'(res_ch) == m_ch[i]) && b;
        end
        for (int i = 0; i < NS; i++) begin
            if (hit[i]) m_flag[i] = 1;
            else if (wr_en && int'(wr_addr) == CLR && wr_data[i]) m_flag[i] = 0;
        end
        if (wr_en && int'(wr_addr) != CLR) begin
            slot = int'(wr_addr) / 4;
            fld  = int'(wr_addr) % 4;
            if (slot < NS) begin
                if (fld == 0) begin
                    m_ch[slot]   = int'(wr_data) % 64;
                    m_mode[slot] = (int'(wr_data) / 256) % 4;
                    m_en[slot]   = wr_data[12];
                end else if (fld == 1) m_lo[slot] = int'(wr_data) % 1024;
                else if (fld == 2)     m_hi[slot] = int'(wr_data) % 1024;
            end
        end
    endfunction

    task automatic tick();
        logic [NS-1:0] ef;
        logic          ei;
        @(posedge clk);
        model_step();
        @(negedge clk);
        ei = 1'b0;
        for (int i = 0; i < NS; i++) begin
            ef[i] = m_flag[i];
            ei = ei | (m_flag[i] & m_en[i]);
        end
        vectors++;
        if (flags !== ef || irq !== ei) begin
            miscompares++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b", cur_req, flags, irq, ef, ei);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic res(input int ch, input int v);
        res_valid = 1'b1; res_ch = CW'(ch); res_val = RW'(v);
        tick();
        res_valid = 1'b0;
    endtask

    task automatic cfg(input int s, input int ch, input int mode, input int en, input int lo, input int hi);
        wr(s * 4, ch + mode * 256 + en * 4096);
        wr(s * 4 + 1, lo);
        wr(s * 4 + 2, hi);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: program slots through the register map
        cur_req = "R10";
        cfg(0, 3, 1, 1, 0, 500);
        cfg(1, 3, 2, 0, 100, 1023);
        cfg(2, 5, 3, 1, 200, 300);
        cfg(3, 3, 0, 1, 0, 0);
        cfg(4, 7, 1, 0, 0, 0);
        cfg(5, 3, 3, 1, 100, 500);

        // R2: channel mismatch and missing strobe do nothing
        cur_req = "R2";
        res(4, 1023);
        res_valid = 1'b0; res_ch = 3; res_val = 1023; tick();

        // R6: equality never alarms
        cur_req = "R6";
        res(3, 500); res(3, 100); res(5, 200); res(5, 300);

        // R3: above the high limit (slot 0 and slot 5)
        cur_req = "R3";
        res(3, 501);

        // R7: flags hold over idle cycles
        cur_req = "R7";
        repeat (4) tick();

        // R8: clear only slot 0, then same-cycle set and clear
        cur_req = "R8";
        wr(CLR, 1);
        res_valid = 1'b1; res_ch = 3; res_val = 900;
        wr(CLR, 33);
        res_valid = 1'b0;
        wr(CLR, 63);

        // R4: below the low limit
        cur_req = "R4";
        res(3, 99);
        wr(CLR, 63);

        // R5: outside the window on both sides
        cur_req = "R5";
        res(5, 199); wr(CLR, 4); res(5, 301); wr(CLR, 4); res(5, 250);

        // R9: flag without enable gives no interrupt
        cur_req = "R9";
        res(7, 5);
        repeat (2) tick();
        wr(CLR, 16);

        // R10: same-cycle write uses old limit
        cur_req = "R10";
        res_valid = 1'b1; res_ch = 3; res_val = 600;
        wr(2, 700);
        res_valid = 1'b0;
        res(3, 650);
        wr(CLR, 63);

        // R11: writes to absent slots change nothing
        cur_req = "R11";
        wr(24, 16'h1303); wr(25, 0); wr(26, 0);
        res(3, 1023);
        wr(CLR, 63);

        // R11: mixed random traffic
        for (int n = 0; n < 600; n++) begin
            wr_en     = ($urandom_range(0, 9) < 3);
            wr_addr   = AW'($urandom_range(0, 31));
            wr_data   = DW'($urandom);
            res_valid = ($urandom_range(0, 1) == 1);
            res_ch    = CW'($urandom_range(0, 7));
            res_val   = RW'($urandom);
            tick();
        end
        wr_en = 1'b0; res_valid = 1'b0;

        // R1: reset mid-run
        cur_req = "R1";
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run still going, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule